// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block runs a processor's entry into an interrupt handler as a fixed, uninterruptible routine. It watches a level-sensitive interrupt request and its vector number. When the request is seen at an instruction boundary while interrupts are enabled, the block takes a snapshot of the program counter, status word and stack pointer. It then steps through the same order every time: mask interrupts, push the program counter, push the status word, fetch the handler address from the vector table, and load that address into the program counter.

The architectural registers belong to the surrounding core. The sequencer only reads them and returns write strobes with new values: a clear strobe for the enable flag, stack-pointer updates and a program-counter load. Every stack or table access goes through a single memory port that waits on a ready handshake. The core holds off instruction fetch while `busy_o` is high. After the one-cycle `entry_done_o`, fetch resumes from the loaded program counter.

Top module: `irq_entry_seq`

## Requirements
- R1: A request starts the routine only in a cycle where `irq_req_i`, `int_en_i` and `insn_boundary_i` are all high and the block is idle. With the enable low or the boundary low, no memory access, no busy cycle and no register strobe occurs.
- R2: The first action of the routine is a one-cycle `ie_clr_o` pulse in the cycle after acceptance. No memory access happens before it. The bench treats bit 0 of the status word as the enable flag.
- R3: The first memory access is a write of the captured program counter, zero-extended to the data width, to address SP − 2, where SP is the value captured at acceptance and the word size is 2 bytes.
- R4: The second access writes the captured status word to SP − 4. After each push, `sp_wr_o` pulses with `sp_wdata_o` equal to the address just written, so the stack pointer ends at SP − 4.
- R5: The third access is a read at VEC_BASE + 2 × N. VEC_BASE defaults to 0x0100. N is the vector number captured at acceptance.
- R6: The word returned by that read is loaded into the program counter through `pc_wr_o`/`pc_wdata_o` in the cycle the read completes.
- R7: Each memory access holds request, direction, address and write data steady until `mem_ready_i` is high, and it advances only then.
- R8: `entry_done_o` is high for exactly one cycle, in the cycle after the vector read completes. `busy_o` is high from the mask cycle through the done cycle and low afterwards.
- R9: Once started, the routine cannot be disturbed. Changes to the request, number or enable during it are ignored. A request still pending with interrupts re-enabled is taken as a new entry after done, using the updated registers.
- R10: After synchronous reset, `busy_o`, `ie_clr_o`, `mem_req_o` and `entry_done_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req_i | input | 1 | Pending interrupt request (level) |
| irq_num_i | input | NUM_W | Vector number of the request |
| int_en_i | input | 1 | Interrupt enable flag from the status word |
| insn_boundary_i | input | 1 | Core is between instructions |
| pc_i | input | ADDR_W | Current program counter |
| psw_i | input | DATA_W | Current status word |
| sp_i | input | ADDR_W | Current stack pointer |
| ie_clr_o | output | 1 | Clear the interrupt enable flag |
| pc_wr_o | output | 1 | Load program counter |
| pc_wdata_o | output | ADDR_W | New program counter (handler address) |
| sp_wr_o | output | 1 | Load stack pointer |
| sp_wdata_o | output | ADDR_W | New stack pointer |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | ADDR_W | Byte address of the access |
| mem_wdata_o | output | DATA_W | Write data |
| mem_rdata_i | input | DATA_W | Read data, valid with ready |
| mem_ready_i | input | 1 | Access completes this cycle |
| busy_o | output | 1 | Routine in progress, fetch held |
| entry_done_o | output | 1 | One-cycle completion pulse |

## Verification
The hardest situation to reach is a request that stays pending for the whole routine while its number changes and interrupts are re-enabled part-way through. The first entry must still use the number it captured. The second entry must start only after done and take the freshly loaded program counter and lowered stack pointer. To get there, the stimulus holds the request and boundary high and stalls each memory access by two cycles. It switches the vector number and sets the enable flag again after the mask pulse has been seen. The expected queue holds both entries' six accesses, so any restart or wrong capture shows up as an out-of-order item.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;

    parameter int unsigned ADDR_W      = 16;
    parameter int unsigned DATA_W      = 16;
    parameter int unsigned NUM_W       = 3;
    parameter int unsigned WORD_BYTES  = 2;
    localparam int unsigned NUM_VECTORS = 1 << NUM_W;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] word_t;
    typedef logic [NUM_W-1:0]  vnum_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_MASK,
        ST_PUSH_PC,
        ST_PUSH_PSW,
        ST_VECTOR,
        ST_DONE
    } entry_state_e;

    // Register values frozen when a request is accepted
    typedef struct packed {
        addr_t pc;
        word_t psw;
        addr_t sp;
        vnum_t num;
    } snapshot_t;

    typedef struct packed {
        logic  req;
        logic  we;
        addr_t addr;
        word_t wdata;
    } mem_op_t;

    // Downward-growing stack: next free slot one word below the pointer
    function automatic addr_t push_slot(addr_t sp);
        return sp - addr_t'(WORD_BYTES);
    endfunction

    function automatic addr_t vector_slot(addr_t base, vnum_t num);
        return base + addr_t'(num) * addr_t'(WORD_BYTES);
    endfunction

    function automatic word_t pc_as_word(addr_t pc);
        return word_t'(pc);
    endfunction

    function automatic logic is_mem_state(entry_state_e s);
        return (s == ST_PUSH_PC) || (s == ST_PUSH_PSW) || (s == ST_VECTOR);
    endfunction

endpackage

// File: rtl/irq_entry_ctrl.sv
module irq_entry_ctrl
    import irq_entry_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         req_ok_i,
    input  logic         mem_ready_i,
    output entry_state_e state_o,
    output logic         accept_o
);

    entry_state_e state_q;
    entry_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (req_ok_i)    state_d = ST_MASK;
            ST_MASK:                      state_d = ST_PUSH_PC;
            ST_PUSH_PC:  if (mem_ready_i) state_d = ST_PUSH_PSW;
            ST_PUSH_PSW: if (mem_ready_i) state_d = ST_VECTOR;
            ST_VECTOR:   if (mem_ready_i) state_d = ST_DONE;
            ST_DONE:                      state_d = ST_IDLE;
            default:                      state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    assign state_o  = state_q;
    assign accept_o = (state_q == ST_IDLE) && req_ok_i;

    // R7: a memory step never advances without ready
    a_r7_stall_holds_state: assert property (@(posedge clk) disable iff (rst)
        (is_mem_state(state_q) && !mem_ready_i) |=> $stable(state_q));

    // R9: once started, the routine only returns to idle through done
    a_r9_no_early_idle: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_IDLE && state_q != ST_DONE) |=> (state_q != ST_IDLE));

endmodule

// File: rtl/irq_entry_snap.sv
module irq_entry_snap
    import irq_entry_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      accept_i,
    input  logic      push_done_i,
    input  addr_t     pc_i,
    input  word_t     psw_i,
    input  addr_t     sp_i,
    input  vnum_t     num_i,
    output snapshot_t snap_o
);

    snapshot_t snap_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            snap_q <= '0;
        end else if (accept_i) begin
            snap_q.pc  <= pc_i;
            snap_q.psw <= psw_i;
            snap_q.sp  <= sp_i;
            snap_q.num <= num_i;
        end else if (push_done_i) begin
            snap_q.sp <= push_slot(snap_q.sp);
        end
    end

    assign snap_o = snap_q;

    // R9: the captured number is frozen except at acceptance
    a_r9_num_frozen: assert property (@(posedge clk) disable iff (rst)
        !accept_i |=> $stable(snap_q.num));

endmodule

// File: rtl/irq_entry_addr.sv
module irq_entry_addr
    import irq_entry_pkg::*;
#(
    parameter addr_t VEC_BASE = addr_t'(16'h0100)
)(
    input  entry_state_e state_i,
    input  snapshot_t    snap_i,
    output mem_op_t      op_o,
    output addr_t        sp_next_o
);

    always_comb begin
        op_o = '0;
        unique case (state_i)
            ST_PUSH_PC: begin
                op_o.req   = 1'b1;
                op_o.we    = 1'b1;
                op_o.addr  = push_slot(snap_i.sp);
                op_o.wdata = pc_as_word(snap_i.pc);
            end
            ST_PUSH_PSW: begin
                op_o.req   = 1'b1;
                op_o.we    = 1'b1;
                op_o.addr  = push_slot(snap_i.sp);
                op_o.wdata = snap_i.psw;
            end
            ST_VECTOR: begin
                op_o.req   = 1'b1;
                op_o.we    = 1'b0;
                op_o.addr  = vector_slot(VEC_BASE, snap_i.num);
            end
            default: op_o = '0;
        endcase
    end

    assign sp_next_o = push_slot(snap_i.sp);

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
    import irq_entry_pkg::*;
#(
    parameter addr_t VEC_BASE = addr_t'(16'h0100)
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              irq_req_i,
    input  logic [NUM_W-1:0]  irq_num_i,
    input  logic              int_en_i,
    input  logic              insn_boundary_i,
    input  logic [ADDR_W-1:0] pc_i,
    input  logic [DATA_W-1:0] psw_i,
    input  logic [ADDR_W-1:0] sp_i,
    output logic              ie_clr_o,
    output logic              pc_wr_o,
    output logic [ADDR_W-1:0] pc_wdata_o,
    output logic              sp_wr_o,
    output logic [ADDR_W-1:0] sp_wdata_o,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    input  logic [DATA_W-1:0] mem_rdata_i,
    input  logic              mem_ready_i,
    output logic              busy_o,
    output logic              entry_done_o
);

    entry_state_e state;
    logic         accept;
    logic         req_ok;
    logic         push_done;
    snapshot_t    snap;
    mem_op_t      op;
    addr_t        sp_next;

    assign req_ok = irq_req_i && int_en_i && insn_boundary_i;

    irq_entry_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .req_ok_i    (req_ok),
        .mem_ready_i (mem_ready_i),
        .state_o     (state),
        .accept_o    (accept)
    );

    irq_entry_snap u_snap (
        .clk         (clk),
        .rst         (rst),
        .accept_i    (accept),
        .push_done_i (push_done),
        .pc_i        (pc_i),
        .psw_i       (psw_i),
        .sp_i        (sp_i),
        .num_i       (irq_num_i),
        .snap_o      (snap)
    );

    irq_entry_addr #(.VEC_BASE(VEC_BASE)) u_addr (
        .state_i   (state),
        .snap_i    (snap),
        .op_o      (op),
        .sp_next_o (sp_next)
    );

    assign push_done    = ((state == ST_PUSH_PC) || (state == ST_PUSH_PSW)) && mem_ready_i;

    assign ie_clr_o     = (state == ST_MASK);
    assign busy_o       = (state != ST_IDLE);
    assign entry_done_o = (state == ST_DONE);

    assign mem_req_o    = op.req;
    assign mem_we_o     = op.we;
    assign mem_addr_o   = op.addr;
    assign mem_wdata_o  = op.wdata;

    assign sp_wr_o      = push_done;
    assign sp_wdata_o   = sp_next;
    assign pc_wr_o      = (state == ST_VECTOR) && mem_ready_i;
    assign pc_wdata_o   = mem_rdata_i[ADDR_W-1:0];

    // R1: the routine begins only after a qualified request
    a_r1_accept_gated: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> $past(irq_req_i && int_en_i && insn_boundary_i));

    // R2: masking is the first visible action
    a_r2_mask_first: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> (ie_clr_o && !mem_req_o));

    // R2: mask, memory access and done never overlap
    a_r2_single_action: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ie_clr_o, mem_req_o, entry_done_o}));

    // R4: the stack pointer update names the slot just written
    a_r4_sp_matches_push: assert property (@(posedge clk) disable iff (rst)
        sp_wr_o |-> (mem_req_o && mem_we_o && mem_ready_i && sp_wdata_o == mem_addr_o));

    // R6: the program counter is loaded only from a completing read
    a_r6_pc_from_read: assert property (@(posedge clk) disable iff (rst)
        pc_wr_o |-> (mem_req_o && !mem_we_o && mem_ready_i));

    // R7: a waiting access keeps its request steady
    a_r7_hold_request: assert property (@(posedge clk) disable iff (rst)
        (mem_req_o && !mem_ready_i) |=>
            (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o) && $stable(mem_wdata_o)));

    // R8: done lasts one cycle and ends the busy window
    a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
        entry_done_o |=> (!entry_done_o && !busy_o));

    // R9: busy cannot drop before done
    a_r9_busy_until_done: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !entry_done_o) |=> busy_o);

endmodule

// File: tb/irq_entry_seq_bench.sv
module irq_entry_seq_bench;
    import irq_entry_pkg::*;

    localparam int    CLK_PERIOD   = 10;
    localparam int    SAMPLE_DELAY = 8;
    localparam addr_t VEC_BASE     = 16'h0100;

    logic  clk = 1'b0;
    logic  rst;
    logic  irq_req, boundary;
    vnum_t irq_num;
    addr_t pc_r, sp_r;
    word_t psw_r;
    logic  ie_clr, pc_wr, sp_wr, mem_req, mem_we, busy, done;
    addr_t pc_wdata, sp_wdata, mem_addr;
    word_t mem_wdata;
    word_t mem_rdata = '0;
    logic  mem_ready = 1'b0;

    irq_entry_seq #(.VEC_BASE(VEC_BASE)) u_irq_entry_seq (
        .clk(clk), .rst(rst),
        .irq_req_i(irq_req), .irq_num_i(irq_num), .int_en_i(psw_r[0]),
        .insn_boundary_i(boundary),
        .pc_i(pc_r), .psw_i(psw_r), .sp_i(sp_r),
        .ie_clr_o(ie_clr), .pc_wr_o(pc_wr), .pc_wdata_o(pc_wdata),
        .sp_wr_o(sp_wr), .sp_wdata_o(sp_wdata),
        .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
        .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .mem_ready_i(mem_ready),
        .busy_o(busy), .entry_done_o(done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        logic  we;
        addr_t addr;
        word_t data;
        string req;
    } exp_op_t;

    exp_op_t exp_q[$];
    word_t   mem [int];
    int      checks = 0, fails = 0;
    int      stall_len = 0, stall_cnt = 0;
    int      hs_count = 0, busy_cycles = 0, done_count = 0;
    logic    masked = 1'b0, prev_done = 1'b0, set_ie_req = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic word_t handler_of(int k);
        return word_t'(32'h4000 + k * 32'h0124);
    endfunction

    function automatic addr_t table_addr(int k);
        return addr_t'(32'h0100 + 2 * k);
    endfunction

    task automatic push_exp(input logic we, input addr_t a, input word_t d, input string r);
        exp_op_t e;
        e.we = we; e.addr = a; e.data = d; e.req = r;
        exp_q.push_back(e);
    endtask

    // Memory responder: ready after stall_len waiting cycles, one idle cycle between accesses
    always @(negedge clk) begin
        if (mem_ready) begin
            mem_ready = 1'b0;
            stall_cnt = 0;
        end else if (mem_req) begin
            if (stall_cnt >= stall_len) begin
                mem_ready = 1'b1;
                mem_rdata = mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : '0;
            end else begin
                stall_cnt++;
            end
        end else begin
            stall_cnt = 0;
        end
    end

    // Monitor / scoreboard: samples just before each rising edge
    always begin
        @(posedge clk);
        #(SAMPLE_DELAY);
        if (!rst) begin
            if (busy) busy_cycles++;
            if (ie_clr) begin
                masked   = 1'b1;
                psw_r[0] = 1'b0;
            end else if (set_ie_req) begin
                psw_r[0]   = 1'b1;
                set_ie_req = 1'b0;
            end
            if (mem_req && !mem_ready && exp_q.size() > 0)
                check(mem_addr == exp_q[0].addr, "R7", "address while waiting",
                      mem_addr, exp_q[0].addr);
            if (mem_req && mem_ready) begin
                hs_count++;
                check(masked, "R2", "access before mask", masked, 1);
                if (exp_q.size() == 0) begin
                    check(1'b0, "R9", "unexpected access", mem_addr, 0);
                end else begin
                    exp_op_t e;
                    e = exp_q.pop_front();
                    check(mem_we == e.we, e.req, "access direction", mem_we, e.we);
                    check(mem_addr == e.addr, e.req, "access address", mem_addr, e.addr);
                    if (e.we)
                        check(mem_wdata == e.data, e.req, "pushed data", mem_wdata, e.data);
                end
                if (mem_we) mem[int'(mem_addr)] = mem_wdata;
            end
            if (sp_wr) sp_r = sp_wdata;
            if (pc_wr) pc_r = pc_wdata;
            if (done) begin
                check(!prev_done, "R8", "done longer than one cycle", prev_done, 0);
                done_count++;
                masked = 1'b0;
            end
            prev_done = done;
        end
    end

    task automatic wait_done(input int target);
        int guard = 0;
        while (done_count < target && guard < 2000) begin
            @(negedge clk);
            guard++;
        end
        check(done_count >= target, "R8", "entry completion", done_count, target);
    endtask

    task automatic run_entry(input int n, input addr_t pc0, input word_t psw0,
                             input addr_t sp0, input int stall);
        int d0;
        @(negedge clk);
        pc_r = pc0; psw_r = psw0; sp_r = sp0; stall_len = stall;
        push_exp(1'b1, sp0 - 16'd2, word_t'(pc0), "R3");
        push_exp(1'b1, sp0 - 16'd4, psw0, "R4");
        push_exp(1'b0, table_addr(n), '0, "R5");
        d0 = done_count;
        irq_num = vnum_t'(n); irq_req = 1'b1; boundary = 1'b1;
        wait_done(d0 + 1);
        irq_req = 1'b0; boundary = 1'b0;
        check(pc_r == handler_of(n), "R6", "program counter loaded", pc_r, handler_of(n));
        check(sp_r == sp0 - 16'd4, "R4", "final stack pointer", sp_r, sp0 - 16'd4);
        check(psw_r[0] == 1'b0, "R2", "enable cleared", psw_r[0], 0);
        check(busy == 1'b0, "R8", "busy after done", busy, 0);
        check(exp_q.size() == 0, "R3", "accesses outstanding", exp_q.size(), 0);
    endtask

    task automatic idle_probe(input word_t psw0, input logic bnd, input string r);
        int h0, b0;
        addr_t p0;
        @(negedge clk);
        psw_r = psw0; boundary = bnd;
        h0 = hs_count; b0 = busy_cycles; p0 = pc_r;
        irq_num = 3'd4; irq_req = 1'b1;
        repeat (8) @(negedge clk);
        check(hs_count == h0, r, "memory access while blocked", hs_count, h0);
        check(busy_cycles == b0, r, "busy while blocked", busy_cycles, b0);
        check(pc_r == p0, r, "program counter while blocked", pc_r, p0);
        irq_req = 1'b0; boundary = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        checks++; fails++;
        $display("FAIL R8 watchdog expired: actual %0d expected %0d", done_count, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        rst = 1'b1; irq_req = 1'b0; boundary = 1'b0; irq_num = '0;
        pc_r = 16'h0000; psw_r = '0; sp_r = 16'h8000;
        for (int k = 0; k < NUM_VECTORS; k++) mem[int'(table_addr(k))] = handler_of(k);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(busy == 1'b0,    "R10", "busy after reset", busy, 0);
        check(ie_clr == 1'b0,  "R10", "mask after reset", ie_clr, 0);
        check(mem_req == 1'b0, "R10", "request after reset", mem_req, 0);
        check(done == 1'b0,    "R10", "done after reset", done, 0);

        // Plain entries: no stall, long stall at the top vector, vector zero
        run_entry(3, 16'h1234, 16'h00A1, 16'h8000, 0);
        run_entry(7, 16'hFFFE, 16'h5A5B, 16'h0010, 3);
        run_entry(0, 16'h0042, 16'h8001, 16'h7FF6, 1);

        // R1: blocked by disabled interrupts, then by a missing boundary
        idle_probe(16'h0000, 1'b1, "R1");
        idle_probe(16'h0001, 1'b0, "R1");

        // R9: request held, number changed and enable restored mid-routine
        begin
            int d0;
            @(negedge clk);
            pc_r = 16'h2000; psw_r = 16'h0301; sp_r = 16'h9000; stall_len = 2;
            push_exp(1'b1, 16'h8FFE, 16'h2000, "R9");
            push_exp(1'b1, 16'h8FFC, 16'h0301, "R9");
            push_exp(1'b0, table_addr(2), '0, "R9");
            push_exp(1'b1, 16'h8FFA, handler_of(2), "R9");
            push_exp(1'b1, 16'h8FF8, 16'h0301, "R9");
            push_exp(1'b0, table_addr(5), '0, "R9");
            d0 = done_count;
            irq_num = 3'd2; irq_req = 1'b1; boundary = 1'b1;
            repeat (3) @(negedge clk);
            irq_num = 3'd5;
            set_ie_req = 1'b1;
            wait_done(d0 + 2);
            irq_req = 1'b0; boundary = 1'b0;
            repeat (4) @(negedge clk);
            check(pc_r == handler_of(5), "R9", "second handler loaded", pc_r, handler_of(5));
            check(sp_r == 16'h8FF8, "R9", "stack after two entries", sp_r, 16'h8FF8);
            check(psw_r[0] == 1'b0, "R9", "enable cleared again", psw_r[0], 0);
            check(done_count == d0 + 2, "R9", "entry count", done_count, d0 + 2);
            check(exp_q.size() == 0, "R9", "accesses outstanding", exp_q.size(), 0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule